// File: doc/BRIEF.md
# Load Queue with Sentinel Slot and Tail Squash

This block is the ordering queue for loads in an out-of-order core. Loads are written at the tail in program order. Each entry holds the load's sequence number and a tag that names the store-queue slot the load follows. When no stores are in flight, the tag holds a reserved "no older store" value instead. Retirement drains the head: every head entry whose sequence number is at or below the committed sequence number leaves in the same cycle. A squash drains the tail: every entry younger than the squash number is removed, youngest first, and the tail moves back over each freed slot.

The ring has one more physical slot than its configured depth. That spare slot separates the full condition from the empty one using only the two pointers. The block reports its occupancy, full and empty flags, and a free-entry figure for dispatch. That figure is the smaller of the load-queue and store-queue free counts, less one. A recorded "blocked load" condition is cleared when a squash reaches back past it.

Commit, squash and allocation may all arrive in one cycle. Commit is applied first, then squash, and a squash cancels any allocation in the same cycle. An allocation that arrives while the queue is full is dropped and raises an overflow flag for one cycle.

Top module: `ldq_sentinel_ring`

## Requirements
- R1: After synchronous active-low reset, the queue is empty: count 0, empty 1, full 0, head and tail index 0, overflow 0, blocked 0, and head sequence and tag outputs 0.
- R2: The queue holds at most LQ_DEPTH loads. Full is 1 exactly when the count equals LQ_DEPTH, which is the case where tail plus one (mod LQ_DEPTH+1) equals head. Empty is 1 exactly when the count is 0.
- R3: An allocation without squash while full leaves the queue contents, count and pointers unchanged. In that case overflow_o is 1 in the following cycle only. Overflow is otherwise 0.
- R4: An accepted load records its sequence number and a tag of width SQ index + 1. The tag is {1'b0, sq_tail_i} when sq_count_i is non-zero, and {1'b1, zeros} (the no-older-store marker) when sq_count_i is 0. The head outputs show the oldest entry's sequence number and tag, or 0 when the queue is empty.
- R5: With commit valid, all consecutive entries from the head whose sequence number is less than or equal to commit_seq_i retire in one cycle. Retirement stops at the first younger entry.
- R6: With squash valid, all consecutive entries from the tail whose sequence number is greater than squash_seq_i are removed in one cycle, and the tail moves back by that number. An entry equal to the squash number stays.
- R7: Head and tail indices count up through 0..LQ_DEPTH and wrap to 0 past LQ_DEPTH. A move back from 0 wraps to LQ_DEPTH. A newly allocated load takes the current tail index.
- R8: free_count_o equals min(LQ_DEPTH+1-count, SQ_DEPTH+1-sq_count_i) - 1. It is combinational on the current count and sq_count_i.
- R9: block_set_i records a blocked load with sequence number block_seq_i. A squash whose number is strictly less than that recorded number clears the blocked state. A squash whose number is equal or greater leaves it set. When a set and a clear fall in the same cycle, the set wins.
- R10: When commit, squash and allocation coincide, commit is applied first, then squash on the entries that remain, and the allocation is dropped without raising overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid_i | input | 1 | Request to append a load |
| alloc_seq_i | input | SEQ_W | Sequence number of the new load |
| sq_tail_i | input | SQ_IDX_W | Current store-queue tail index |
| sq_count_i | input | SQ_CNT_W | Current store-queue occupancy |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Squash number; younger loads are removed |
| block_set_i | input | 1 | Record a blocked load |
| block_seq_i | input | SEQ_W | Sequence number of the blocked load |
| lq_count_o | output | CNT_W | Loads held |
| lq_full_o | output | 1 | Queue full |
| lq_empty_o | output | 1 | Queue empty |
| free_count_o | output | FREE_W | Free entries available to dispatch |
| overflow_o | output | 1 | Allocation dropped while full (one cycle) |
| head_idx_o | output | IDX_W | Index of the oldest slot |
| tail_idx_o | output | IDX_W | Index the next load receives |
| head_seq_o | output | SEQ_W | Sequence number of the oldest load |
| head_tag_o | output | TAG_W | Store-queue tag of the oldest load |
| load_blocked_o | output | 1 | Blocked-load state |

## Verification
The bench targets several corner cases, each tied to the failure it would expose:
- Multi-entry commit that must stop at the first younger load. A design that retired only one entry per cycle, or skipped past a younger one, would leave the head sequence wrong.
- A squash whose number equals a held load. An off-by-one compare would remove that load and pull the tail back one slot too far.
- Pointer wrap in both directions around the sentinel slot. A ring sized without the spare slot would report full one load early, or alias full with empty.
- Coinciding commit, squash and allocation, plus allocation while full. These expose a design that squashes before committing, or that writes over the head.
- The strict less-than rule for clearing the blocked state.

// File: rtl/ldq_pkg.sv
// Package: ring-index helpers shared by the load queue modules.
// Assumes slot counts small enough to fit in an int.
package ldq_pkg;
    // Move an index by delta (either sign) around a ring of 'slots' entries.
    function automatic int ring_step(input int idx, input int delta, input int slots);
        int r;
        r = (idx + delta) % slots;
        if (r < 0) r = r + slots;
        return r;
    endfunction
endpackage

// File: rtl/ldq_retire_scan.sv
// Counts how many loads leave from the head on a commit. Walks from the
// head while entries are live and not younger than the commit number.
// Assumes entries are stored in increasing sequence order from the head.
module ldq_retire_scan #(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic [IDX_W-1:0] head_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             commit_valid_i,
    input  logic [SEQ_W-1:0] commit_seq_i,
    input  logic [SEQ_W-1:0] seq_arr_i [SLOTS],
    output logic [CNT_W-1:0] n_retire_o
);
    import ldq_pkg::*;

    // Prefix count of retirable entries starting at the head.
    always_comb begin
        logic go;
        int   idx;
        n_retire_o = '0;
        go = commit_valid_i;
        for (int k = 0; k < SLOTS; k++) begin
            idx = ring_step(int'(head_i), k, SLOTS);
            if (go && (k < int'(count_i)) && (seq_arr_i[IDX_W'(idx)] <= commit_seq_i))
                n_retire_o = n_retire_o + CNT_W'(1);
            else
                go = 1'b0;
        end
    end
endmodule

// File: rtl/ldq_squash_scan.sv
// Counts how many loads a squash removes. Walks back from the slot before
// the tail while entries remain after retirement and are younger than the
// squash number. Assumes increasing sequence order from head to tail.
module ldq_squash_scan #(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic [IDX_W-1:0] tail_i,
    input  logic [CNT_W-1:0] live_i,
    input  logic             squash_valid_i,
    input  logic [SEQ_W-1:0] squash_seq_i,
    input  logic [SEQ_W-1:0] seq_arr_i [SLOTS],
    output logic [CNT_W-1:0] n_squash_o
);
    import ldq_pkg::*;

    // Suffix count of entries younger than the squash number.
    always_comb begin
        logic go;
        int   idx;
        n_squash_o = '0;
        go = squash_valid_i;
        for (int k = 0; k < SLOTS; k++) begin
            idx = ring_step(int'(tail_i), -1 - k, SLOTS);
            if (go && (k < int'(live_i)) && (seq_arr_i[IDX_W'(idx)] > squash_seq_i))
                n_squash_o = n_squash_o + CNT_W'(1);
            else
                go = 1'b0;
        end
    end
endmodule

// File: rtl/ldq_space_calc.sv
// Derives the full flag from the two pointers (sentinel rule) and the
// dispatch free count from load and store occupancy.
// Assumes sq_count_i never exceeds the store-queue depth.
module ldq_space_calc #(
    parameter int LQ_SLOTS = 5,
    parameter int SQ_SLOTS = 5,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 3,
    parameter int SQ_CNT_W = 3,
    parameter int FREE_W   = 3
) (
    input  logic [IDX_W-1:0]    head_i,
    input  logic [IDX_W-1:0]    tail_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [SQ_CNT_W-1:0] sq_count_i,
    output logic                full_o,
    output logic [FREE_W-1:0]   free_o
);
    import ldq_pkg::*;

    // Full when advancing the tail would land on the head.
    always_comb full_o = (ring_step(int'(tail_i), 1, LQ_SLOTS) == int'(head_i));

    // Smaller of the two free counts, less the sentinel slot.
    always_comb begin
        int lq_free;
        int sq_free;
        lq_free = LQ_SLOTS - int'(count_i);
        sq_free = SQ_SLOTS - int'(sq_count_i);
        free_o  = FREE_W'(((lq_free < sq_free) ? lq_free : sq_free) - 1);
    end
endmodule

// File: rtl/ldq_sentinel_ring.sv
// Load queue ring for an out-of-order core. Appends loads in program order,
// retires from the head by committed sequence number, and removes younger
// loads from the tail on a squash. Per cycle, commit is applied first, then
// squash, then (only without squash) allocation. One slot beyond LQ_DEPTH
// is kept as a sentinel. Assumes sequence numbers do not wrap while loads
// are held.
module ldq_sentinel_ring #(
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 4,
    parameter int SEQ_W    = 16,
    localparam int LQ_SLOTS = LQ_DEPTH + 1,
    localparam int SQ_SLOTS = SQ_DEPTH + 1,
    localparam int IDX_W    = $clog2(LQ_SLOTS),
    localparam int CNT_W    = $clog2(LQ_SLOTS + 1),
    localparam int SQ_IDX_W = $clog2(SQ_SLOTS),
    localparam int SQ_CNT_W = $clog2(SQ_SLOTS + 1),
    localparam int TAG_W    = SQ_IDX_W + 1,
    localparam int FREE_W   = $clog2(((LQ_SLOTS > SQ_SLOTS) ? LQ_SLOTS : SQ_SLOTS) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid_i,
    input  logic [SEQ_W-1:0]    alloc_seq_i,
    input  logic [SQ_IDX_W-1:0] sq_tail_i,
    input  logic [SQ_CNT_W-1:0] sq_count_i,
    input  logic                commit_valid_i,
    input  logic [SEQ_W-1:0]    commit_seq_i,
    input  logic                squash_valid_i,
    input  logic [SEQ_W-1:0]    squash_seq_i,
    input  logic                block_set_i,
    input  logic [SEQ_W-1:0]    block_seq_i,
    output logic [CNT_W-1:0]    lq_count_o,
    output logic                lq_full_o,
    output logic                lq_empty_o,
    output logic [FREE_W-1:0]   free_count_o,
    output logic                overflow_o,
    output logic [IDX_W-1:0]    head_idx_o,
    output logic [IDX_W-1:0]    tail_idx_o,
    output logic [SEQ_W-1:0]    head_seq_o,
    output logic [TAG_W-1:0]    head_tag_o,
    output logic                load_blocked_o
);
    import ldq_pkg::*;

    localparam logic [TAG_W-1:0] NO_STORE_TAG = {1'b1, {SQ_IDX_W{1'b0}}};

    logic [SEQ_W-1:0] seq_mem [LQ_SLOTS];
    logic [TAG_W-1:0] tag_mem [LQ_SLOTS];
    logic [IDX_W-1:0] head_q, tail_q, tail_back, head_next, tail_next;
    logic [CNT_W-1:0] count_q, n_retire, n_squash, live_after_commit;
    logic             full, alloc_do, ovf_q, blk_q;
    logic [SEQ_W-1:0] blk_seq_q;
    logic [TAG_W-1:0] new_tag;

    // Head-side retirement count.
    ldq_retire_scan #(.SLOTS(LQ_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_retire (
        .head_i(head_q), .count_i(count_q), .commit_valid_i(commit_valid_i),
        .commit_seq_i(commit_seq_i), .seq_arr_i(seq_mem), .n_retire_o(n_retire));

    // Entries left after commit, the pool the squash may draw from.
    always_comb live_after_commit = count_q - n_retire;

    // Tail-side squash count.
    ldq_squash_scan #(.SLOTS(LQ_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_squash (
        .tail_i(tail_q), .live_i(live_after_commit), .squash_valid_i(squash_valid_i),
        .squash_seq_i(squash_seq_i), .seq_arr_i(seq_mem), .n_squash_o(n_squash));

    // Full flag and dispatch free count.
    ldq_space_calc #(.LQ_SLOTS(LQ_SLOTS), .SQ_SLOTS(SQ_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W),
                     .SQ_CNT_W(SQ_CNT_W), .FREE_W(FREE_W)) u_space (
        .head_i(head_q), .tail_i(tail_q), .count_i(count_q), .sq_count_i(sq_count_i),
        .full_o(full), .free_o(free_count_o));

    // Next pointers, acceptance and the tag for a new load.
    always_comb begin
        alloc_do  = alloc_valid_i && !squash_valid_i && !full;
        head_next = IDX_W'(ring_step(int'(head_q), int'(n_retire), LQ_SLOTS));
        tail_back = IDX_W'(ring_step(int'(tail_q), -int'(n_squash), LQ_SLOTS));
        tail_next = alloc_do ? IDX_W'(ring_step(int'(tail_back), 1, LQ_SLOTS)) : tail_back;
        new_tag   = (sq_count_i == '0) ? NO_STORE_TAG : {1'b0, sq_tail_i};
    end

    // Pointer, occupancy and overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            head_q  <= head_next;
            tail_q  <= tail_next;
            count_q <= count_q - n_retire - n_squash + CNT_W'(alloc_do);
            ovf_q   <= alloc_valid_i && !squash_valid_i && full;
        end
    end

    // Entry storage: write the new load at the post-squash tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LQ_SLOTS; s++) begin
                seq_mem[s] <= '0;
                tag_mem[s] <= '0;
            end
        end else if (alloc_do) begin
            seq_mem[tail_back] <= alloc_seq_i;
            tag_mem[tail_back] <= new_tag;
        end
    end

    // Blocked-load state: an older squash clears, a new set takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q     <= 1'b0;
            blk_seq_q <= '0;
        end else if (block_set_i) begin
            blk_q     <= 1'b1;
            blk_seq_q <= block_seq_i;
        end else if (squash_valid_i && blk_q && (squash_seq_i < blk_seq_q)) begin
            blk_q     <= 1'b0;
            blk_seq_q <= '0;
        end
    end

    // Output drive.
    always_comb begin
        lq_count_o     = count_q;
        lq_full_o      = full;
        lq_empty_o     = (count_q == '0);
        overflow_o     = ovf_q;
        head_idx_o     = head_q;
        tail_idx_o     = tail_q;
        head_seq_o     = lq_empty_o ? '0 : seq_mem[head_q];
        head_tag_o     = lq_empty_o ? '0 : tag_mem[head_q];
        load_blocked_o = blk_q;
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= LQ_DEPTH);
    // R2
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (int'(count_q) == LQ_DEPTH));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !squash_valid_i && !commit_valid_i && full)
        |=> (overflow_o && $stable(count_q) && $stable(tail_q)));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_valid_i && !commit_valid_i && !squash_valid_i)
        |=> ($stable(count_q) && $stable(head_q) && $stable(tail_q)));
    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(head_q) < LQ_SLOTS) && (int'(tail_q) < LQ_SLOTS));
    // R9
    blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid_i && blk_q && (squash_seq_i < blk_seq_q) && !block_set_i)
        |=> !load_blocked_o);
    // R10
    squash_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid_i && alloc_valid_i) |=> !overflow_o);
endmodule

// File: tb/test_ldq_sentinel_ring.sv
`timescale 1ns/1ps
module test_ldq_sentinel_ring;
    localparam int LQ_DEPTH = 4;
    localparam int SQ_DEPTH = 4;
    localparam int SEQ_W    = 16;
    localparam int LQ_SLOTS = LQ_DEPTH + 1;
    localparam int SQ_SLOTS = SQ_DEPTH + 1;
    localparam int IDX_W    = $clog2(LQ_SLOTS);
    localparam int CNT_W    = $clog2(LQ_SLOTS + 1);
    localparam int SQ_IDX_W = $clog2(SQ_SLOTS);
    localparam int SQ_CNT_W = $clog2(SQ_SLOTS + 1);
    localparam int TAG_W    = SQ_IDX_W + 1;
    localparam int FREE_W   = $clog2(((LQ_SLOTS > SQ_SLOTS) ? LQ_SLOTS : SQ_SLOTS) + 1);
    localparam int MARKER   = 1 << SQ_IDX_W;

    logic clk = 0, rst_n = 0;
    logic alloc_valid_i = 0, commit_valid_i = 0, squash_valid_i = 0, block_set_i = 0;
    logic [SEQ_W-1:0] alloc_seq_i = 0, commit_seq_i = 0, squash_seq_i = 0, block_seq_i = 0;
    logic [SQ_IDX_W-1:0] sq_tail_i = 0;
    logic [SQ_CNT_W-1:0] sq_count_i = 0;
    logic [CNT_W-1:0] lq_count_o;
    logic lq_full_o, lq_empty_o, overflow_o, load_blocked_o;
    logic [FREE_W-1:0] free_count_o;
    logic [IDX_W-1:0] head_idx_o, tail_idx_o;
    logic [SEQ_W-1:0] head_seq_o;
    logic [TAG_W-1:0] head_tag_o;

    always #2 clk = ~clk;

    ldq_sentinel_ring #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W)) i_ldq_sentinel_ring (
        .clk(clk), .rst_n(rst_n), .alloc_valid_i(alloc_valid_i), .alloc_seq_i(alloc_seq_i),
        .sq_tail_i(sq_tail_i), .sq_count_i(sq_count_i), .commit_valid_i(commit_valid_i),
        .commit_seq_i(commit_seq_i), .squash_valid_i(squash_valid_i), .squash_seq_i(squash_seq_i),
        .block_set_i(block_set_i), .block_seq_i(block_seq_i), .lq_count_o(lq_count_o),
        .lq_full_o(lq_full_o), .lq_empty_o(lq_empty_o), .free_count_o(free_count_o),
        .overflow_o(overflow_o), .head_idx_o(head_idx_o), .tail_idx_o(tail_idx_o),
        .head_seq_o(head_seq_o), .head_tag_o(head_tag_o), .load_blocked_o(load_blocked_o));

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    int mseq[$];
    int mtag[$];
    int mhead = 0, mtail = 0, mblk = 0, mblkseq = 0, movf = 0, next_seq = 1;
    string ctx = "R7";
    int unsigned lfsr = 32'h1234_5678;

    function automatic int unsigned rnd();
        lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    function automatic int wrap(input int v);
        return ((v % LQ_SLOTS) + LQ_SLOTS) % LQ_SLOTS;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output against the model state and current inputs.
    task automatic compare_all();
        int sz, lf, sf, fr;
        sz = mseq.size();
        lf = LQ_SLOTS - sz; sf = SQ_SLOTS - int'(sq_count_i);
        fr = ((lf < sf) ? lf : sf) - 1;
        chk(int'(lq_count_o) == sz, "R2", "count", int'(lq_count_o), sz);
        chk(lq_full_o == (sz == LQ_DEPTH), "R2", "full", int'(lq_full_o), int'(sz == LQ_DEPTH));
        chk(lq_empty_o == (sz == 0), "R2", "empty", int'(lq_empty_o), int'(sz == 0));
        chk(int'(overflow_o) == movf, "R3", "overflow", int'(overflow_o), movf);
        chk(int'(head_seq_o) == (sz ? mseq[0] : 0), "R5", "head_seq", int'(head_seq_o), sz ? mseq[0] : 0);
        chk(int'(head_tag_o) == (sz ? mtag[0] : 0), "R4", "head_tag", int'(head_tag_o), sz ? mtag[0] : 0);
        chk(int'(head_idx_o) == mhead, "R7", "head_idx", int'(head_idx_o), mhead);
        chk(int'(tail_idx_o) == mtail, ctx, "tail_idx", int'(tail_idx_o), mtail);
        chk(int'(free_count_o) == fr, "R8", "free_count", int'(free_count_o), fr);
        chk(int'(load_blocked_o) == mblk, "R9", "blocked", int'(load_blocked_o), mblk);
    endtask

    // Model one clock edge from the inputs currently driven.
    task automatic model_update();
        int pre;
        pre = mseq.size();
        ctx = "R7";
        if (commit_valid_i)
            while (mseq.size() > 0 && mseq[0] <= int'(commit_seq_i)) begin
                void'(mseq.pop_front()); void'(mtag.pop_front()); mhead = wrap(mhead + 1);
            end
        if (squash_valid_i) begin
            ctx = "R6";
            while (mseq.size() > 0 && mseq[$] > int'(squash_seq_i)) begin
                void'(mseq.pop_back()); void'(mtag.pop_back()); mtail = wrap(mtail - 1);
            end
            if (mblk != 0 && int'(squash_seq_i) < mblkseq) begin mblk = 0; mblkseq = 0; end
        end
        if (block_set_i) begin mblk = 1; mblkseq = int'(block_seq_i); end
        movf = 0;
        if (alloc_valid_i && !squash_valid_i) begin
            if (pre == LQ_DEPTH) movf = 1;
            else begin
                mseq.push_back(int'(alloc_seq_i));
                mtag.push_back((sq_count_i == 0) ? MARKER : int'(sq_tail_i));
                mtail = wrap(mtail + 1);
                next_seq++;
            end
        end
        if (commit_valid_i && squash_valid_i) ctx = "R10";
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        alloc_valid_i = 0; commit_valid_i = 0; squash_valid_i = 0; block_set_i = 0;
        alloc_seq_i = SEQ_W'(next_seq);
    endtask

    task automatic alloc(input int sqc, input int sqt);
        idle();
        alloc_valid_i = 1; sq_count_i = SQ_CNT_W'(sqc); sq_tail_i = SQ_IDX_W'(sqt);
        step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        chk(lq_count_o == 0, "R1", "count", int'(lq_count_o), 0);
        chk(lq_empty_o == 1, "R1", "empty", int'(lq_empty_o), 1);
        chk(lq_full_o == 0, "R1", "full", int'(lq_full_o), 0);
        chk(head_idx_o == 0 && tail_idx_o == 0, "R1", "ptrs", int'(tail_idx_o), 0);
        chk(overflow_o == 0 && load_blocked_o == 0, "R1", "flags", int'(overflow_o), 0);
        chk(head_seq_o == 0 && head_tag_o == 0, "R1", "head", int'(head_seq_o), 0);
        rst_n = 1;
        step();
        // R4 fill with mixed store states; R2 reaches full.
        alloc(0, 3); alloc(2, 1); alloc(0, 0); alloc(3, 4);
        chk(lq_full_o == 1, "R2", "full after depth loads", int'(lq_full_o), 1);
        // R3 allocation while full is dropped.
        alloc(1, 2);
        chk(overflow_o == 1, "R3", "overflow pulse", int'(overflow_o), 1);
        idle(); step();
        chk(overflow_o == 0, "R3", "overflow clears", int'(overflow_o), 0);
        // R5 commit two loads in one cycle.
        idle(); commit_valid_i = 1; commit_seq_i = 2; step();
        chk(head_seq_o == 3, "R5", "head after commit", int'(head_seq_o), 3);
        // R7 wrap the tail.
        alloc(1, 1); alloc(0, 0);
        // R6 squash equal-number boundary.
        idle(); squash_valid_i = 1; squash_seq_i = 4; step();
        chk(lq_count_o == 2, "R6", "count after squash", int'(lq_count_o), 2);
        // R10 all three together.
        alloc(1, 1);
        idle(); alloc_valid_i = 1; commit_valid_i = 1; commit_seq_i = 3;
        squash_valid_i = 1; squash_seq_i = 4; step();
        chk(overflow_o == 0, "R10", "no overflow under squash", int'(overflow_o), 0);
        // R9 blocked load clearing rules.
        idle(); block_set_i = 1; block_seq_i = 10; step();
        idle(); squash_valid_i = 1; squash_seq_i = 10; step();
        chk(load_blocked_o == 1, "R9", "equal squash keeps block", int'(load_blocked_o), 1);
        idle(); squash_valid_i = 1; squash_seq_i = 9; step();
        chk(load_blocked_o == 0, "R9", "older squash clears", int'(load_blocked_o), 0);
        // Random sweep over all commands and store states.
        for (int c = 0; c < 4000; c++) begin
            idle();
            alloc_valid_i  = (rnd() % 3) != 0;
            sq_count_i     = SQ_CNT_W'(rnd() % (SQ_DEPTH + 1));
            sq_tail_i      = SQ_IDX_W'(rnd() % SQ_SLOTS);
            commit_valid_i = (rnd() % 3) == 0;
            commit_seq_i   = SEQ_W'((mseq.size() > 0 ? mseq[0] : next_seq) + int'(rnd() % 4) - 1);
            squash_valid_i = (rnd() % 8) == 0;
            squash_seq_i   = SEQ_W'((next_seq > 4) ? next_seq - 1 - int'(rnd() % 4) : 0);
            block_set_i    = (rnd() % 16) == 0;
            block_seq_i    = SEQ_W'(next_seq - int'(rnd() % 3));
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule